// File: doc/BRIEF.md
# BCD Clock Calendar Core

This block keeps wall-clock time and calendar date in eight byte-wide BCD registers. The registers hold hundredths of a second, seconds, minutes, hours, day of week, date, month and year. Each cycle in which the single-cycle `tick_i` enable is high counts as one hundredth of a second. The carry ripples through the whole chain in that same clock cycle. Month lengths and leap years are worked out from the month and year registers. The hours byte carries its own format select, so the clock can run as a 24-hour clock or as a 12-hour clock with a PM flag.

Two spare bits of the day byte serve as controls. One stops timekeeping. The other is a reset-enable flag that the block only stores, for a serial transfer controller outside it. That controller reads the whole time through the 64-bit `snap_o` word and writes all of it through a valid/ready load port. The load port never applies back-pressure: `load_ready_o` is always high, so every cycle with `load_valid_i` high is one accepted load. A load replaces all eight registers at the same clock edge, and a tick in that cycle is dropped. The controller therefore never sees a partly updated time.

Top module: `bcd_timekeeper`

## Requirements
- R1: While reset is held and at the first cycle after it, `snap_o` reads 64'h0001_0131_0000_0000: date 01, month 01, year 00, all time fields 00, 24-hour mode, day of week 01, and both control bits in the day byte set to 1. `load_ready_o` is high.
- R2: Byte k of `snap_o` and of `load_data_i` (bits 8k+7..8k) is register k. The registers, from k=0 to 7, are: hundredths, seconds, minutes, hours, day, date, month, year.
- R3: While day bit 5 is 0, each accepted tick adds one hundredth of a second. Hundredths wrap from 99 to 00, seconds from 59 to 00 and minutes from 59 to 00. Each wrap adds one to the next register.
- R4: When hours bit 7 is 0 (24-hour mode), bits 5..4 hold the tens of hours and the hour runs 00 to 23. A step from 23 gives 00 and advances both the day of week and the date.
- R5: When hours bit 7 is 1 (12-hour mode), bit 4 holds the tens of hours, bit 5 is the PM flag (1 = PM), and the hour runs 01 to 12. A step from 11 gives 12 and inverts the flag. A step from 12 gives 01 and keeps the flag. The day and date advance only on the step from 11 PM to 12 AM.
- R6: The day of week (day bits 2..0) runs 01 to 07 and wraps from 07 to 01.
- R7: The date wraps to 01 and advances the month after its last value. That last value is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For month 02 it is 29 when the year is divisible by 4 (year 00 included) and 28 otherwise.
- R8: The month wraps from 12 to 01 and then advances the year. The year wraps from 99 to 00.
- R9: While day bit 5 is 1, ticks have no effect and every register keeps its value.
- R10: A load (`load_valid_i` high) writes all eight registers from `load_data_i` at that clock edge, and any tick in the same cycle is dropped. `load_ready_o` is always high.
- R11: Bits that no field uses always read 0, whatever was loaded: bit 7 of seconds and minutes, bit 6 of hours, bits 7, 6 and 3 of day, bits 7..6 of date, bits 7..5 of month.
- R12: Day bit 4 (reset-enable) is stored and read back unchanged until the next load, and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 100 Hz time step enable |
| load_valid_i | input | 1 | Load request, carries `load_data_i` |
| load_ready_o | output | 1 | Load acceptance, always high |
| load_data_i | input | 64 | Eight register bytes to load, byte k = register k |
| snap_o | output | 64 | Current eight register bytes, byte k = register k |

## Verification
The assertions assume that every loaded field is a legal in-range BCD value and that `tick_i` is a one-cycle enable. They do not check an hour loaded outside its mode's range or a date beyond its month. The stimulus loads only legal values, with one exception: an all-ones word that tests the read-as-zero bits. That word also sets the stop bit, so no field steps from an illegal value. The sweeps cover every hour in both formats and every month-end across leap and non-leap years, and they compare each result against arithmetic computed in the bench.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int WORD_W   = BYTE_W * NUM_REGS;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum int {
    IDX_CENTI = 0,
    IDX_SEC   = 1,
    IDX_MIN   = 2,
    IDX_HOUR  = 3,
    IDX_WDAY  = 4,
    IDX_DATE  = 5,
    IDX_MONTH = 6,
    IDX_YEAR  = 7
  } reg_idx_e;

  localparam int WDAY_LSB   = BYTE_W * IDX_WDAY;
  localparam int STOP_BIT   = WDAY_LSB + 5;
  localparam int RSTEN_BIT  = WDAY_LSB + 4;

  // Next BCD value of a two-digit count (no range wrap)
  function automatic byte_t bcd_step(input byte_t v);
    byte_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Bits that exist in each register; the rest read as zero
  function automatic byte_t keep_mask(input int idx);
    byte_t m;
    case (idx)
      IDX_SEC, IDX_MIN: m = 8'h7F;
      IDX_HOUR:         m = 8'hBF;
      IDX_WDAY:         m = 8'h37;
      IDX_DATE:         m = 8'h3F;
      IDX_MONTH:        m = 8'h1F;
      default:          m = 8'hFF;
    endcase
    return m;
  endfunction

  // 10*t + u is a multiple of 4 exactly when 2*t + u is
  function automatic logic leap_year(input byte_t y);
    logic [1:0] s;
    s = y[1:0] + {y[4], 1'b0};
    return (s == 2'b00);
  endfunction

  function automatic byte_t month_last(input byte_t m, input logic leap);
    byte_t d;
    case (m)
      8'h02:                      d = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tk_wrap_counter.sv
module tk_wrap_counter
  import tk_pkg::*;
#(
  parameter byte_t LO  = 8'h00,
  parameter byte_t HI  = 8'h99,
  parameter byte_t RST = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  load_i,
  input  byte_t load_val_i,
  output byte_t value_o,
  output logic  carry_o
);
  byte_t value_q;
  logic  at_top;

  always_comb begin
    at_top  = (value_q >= HI);
    carry_o = step_i && at_top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      value_q <= RST;
    else if (load_i) value_q <= load_val_i;
    else if (step_i) value_q <= at_top ? LO : bcd_step(value_q);
  end

  assign value_o = value_q;

  // R9: no step and no load keeps the count
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(value_q));

  // R3: a carry out leaves the count at its low end
  a_r3_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_o && !load_i) |=> (value_q == LO));
endmodule

// File: rtl/tk_hour_counter.sv
module tk_hour_counter
  import tk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  load_i,
  input  byte_t load_val_i,
  output byte_t value_o,
  output logic  carry_o
);
  byte_t h_q;
  byte_t nxt;
  byte_t step12;
  byte_t step24;
  logic  day_end;

  always_comb begin
    step12  = bcd_step({3'b000, h_q[4:0]});
    step24  = bcd_step({2'b00, h_q[5:0]});
    nxt     = h_q;
    day_end = 1'b0;
    if (h_q[7]) begin
      if (h_q[4:0] == 5'h11) begin
        nxt[4:0] = 5'h12;
        nxt[5]   = ~h_q[5];
        day_end  = h_q[5];
      end else if (h_q[4:0] >= 5'h12) begin
        nxt[4:0] = 5'h01;
      end else begin
        nxt[4:0] = step12[4:0];
      end
    end else begin
      if (h_q[5:0] >= 6'h23) begin
        nxt[5:0] = 6'h00;
        day_end  = 1'b1;
      end else begin
        nxt[5:0] = step24[5:0];
      end
    end
    carry_o = step_i && day_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      h_q <= 8'h00;
    else if (load_i) h_q <= load_val_i;
    else if (step_i) h_q <= nxt;
  end

  assign value_o = h_q;

  // R5: 11 -> 12 inverts the PM flag
  a_r5_flag_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && h_q[7] && h_q[4:0] == 5'h11)
      |=> (h_q[4:0] == 5'h12 && h_q[5] != $past(h_q[5])));

  // R5: 12 -> 01 keeps the PM flag
  a_r5_twelve_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && h_q[7] && h_q[4:0] == 5'h12)
      |=> (h_q[4:0] == 5'h01 && $stable(h_q[5])));

  // R4: 23 -> 00 in 24-hour mode
  a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !h_q[7] && h_q[5:0] == 6'h23) |=> (h_q[5:0] == 6'h00));

  // R11: bit 6 of the hours byte stays zero
  a_r11_hour_gap: assert property (@(posedge clk) disable iff (!rst_n) !h_q[6]);
endmodule

// File: rtl/tk_date_counter.sv
module tk_date_counter
  import tk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  load_i,
  input  byte_t load_val_i,
  input  byte_t month_i,
  input  byte_t year_i,
  output byte_t value_o,
  output logic  carry_o
);
  byte_t d_q;
  byte_t last_day;
  logic  at_end;

  always_comb begin
    last_day = month_last(month_i, leap_year(year_i));
    at_end   = (d_q >= last_day);
    carry_o  = step_i && at_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      d_q <= 8'h01;
    else if (load_i) d_q <= load_val_i;
    else if (step_i) d_q <= at_end ? 8'h01 : bcd_step(d_q);
  end

  assign value_o = d_q;

  // R7: leaving the last day of a month gives day 01
  a_r7_wrap_first: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_o && !load_i) |=> (d_q == 8'h01));

  // R7: February of a non-leap year ends on 28
  a_r7_short_feb: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && month_i == 8'h02 && !leap_year(year_i) && d_q == 8'h28)
      |=> (d_q == 8'h01));

  // R9: idle keeps the date
  a_r9_date_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(d_q));
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_valid_i,
  output logic              load_ready_o,
  input  logic [WORD_W-1:0] load_data_i,
  output logic [WORD_W-1:0] snap_o
);
  byte_t ld_byte [NUM_REGS];
  byte_t cur     [NUM_REGS];
  logic  [WORD_W-1:0] ld_word;

  logic take, adv;
  logic stop_q, rsten_q;
  logic c_centi, c_sec, c_min, c_hour, c_wday, c_date, c_month, c_year;
  byte_t wday_val;

  assign load_ready_o = 1'b1;
  assign take = load_valid_i && load_ready_o;
  assign adv  = tick_i && !stop_q && !take;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_bytes
    assign ld_byte[k] = load_data_i[k*BYTE_W +: BYTE_W] & keep_mask(k);
    assign ld_word[k*BYTE_W +: BYTE_W] = ld_byte[k];
    assign snap_o[k*BYTE_W +: BYTE_W]  = cur[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      rsten_q <= 1'b1;
    end else if (take) begin
      stop_q  <= ld_byte[IDX_WDAY][5];
      rsten_q <= ld_byte[IDX_WDAY][4];
    end
  end

  tk_wrap_counter #(.LO(8'h00), .HI(8'h99), .RST(8'h00)) u_centi (
    .clk(clk), .rst_n(rst_n), .step_i(adv), .load_i(take),
    .load_val_i(ld_byte[IDX_CENTI]), .value_o(cur[IDX_CENTI]), .carry_o(c_centi));

  tk_wrap_counter #(.LO(8'h00), .HI(8'h59), .RST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .step_i(c_centi), .load_i(take),
    .load_val_i(ld_byte[IDX_SEC]), .value_o(cur[IDX_SEC]), .carry_o(c_sec));

  tk_wrap_counter #(.LO(8'h00), .HI(8'h59), .RST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .step_i(c_sec), .load_i(take),
    .load_val_i(ld_byte[IDX_MIN]), .value_o(cur[IDX_MIN]), .carry_o(c_min));

  tk_hour_counter u_hour (
    .clk(clk), .rst_n(rst_n), .step_i(c_min), .load_i(take),
    .load_val_i(ld_byte[IDX_HOUR]), .value_o(cur[IDX_HOUR]), .carry_o(c_hour));

  tk_wrap_counter #(.LO(8'h01), .HI(8'h07), .RST(8'h01)) u_wday (
    .clk(clk), .rst_n(rst_n), .step_i(c_hour), .load_i(take),
    .load_val_i(ld_byte[IDX_WDAY] & 8'h07), .value_o(wday_val), .carry_o(c_wday));

  assign cur[IDX_WDAY] = {2'b00, stop_q, rsten_q, 1'b0, wday_val[2:0]};

  tk_date_counter u_date (
    .clk(clk), .rst_n(rst_n), .step_i(c_hour), .load_i(take),
    .load_val_i(ld_byte[IDX_DATE]), .month_i(cur[IDX_MONTH]), .year_i(cur[IDX_YEAR]),
    .value_o(cur[IDX_DATE]), .carry_o(c_date));

  tk_wrap_counter #(.LO(8'h01), .HI(8'h12), .RST(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .step_i(c_date), .load_i(take),
    .load_val_i(ld_byte[IDX_MONTH]), .value_o(cur[IDX_MONTH]), .carry_o(c_month));

  tk_wrap_counter #(.LO(8'h00), .HI(8'h99), .RST(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .step_i(c_month), .load_i(take),
    .load_val_i(ld_byte[IDX_YEAR]), .value_o(cur[IDX_YEAR]), .carry_o(c_year));

  // R9: with the stop bit set and no load, the snapshot is frozen
  a_r9_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_o[STOP_BIT] && !take) |=> $stable(snap_o));

  // R10: a load shows up whole at the next cycle, tick or not
  a_r10_load_whole: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (snap_o == $past(ld_word)));

  // R12: the reset-enable bit changes only through a load
  a_r12_rsten_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(snap_o[RSTEN_BIT]));

  // R8: a year carry means the year leaves 99
  a_r8_year_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (c_year && !take) |=> (snap_o[IDX_YEAR*BYTE_W +: BYTE_W] == 8'h00));

  // R6: the day of week never reads as 0 after a step
  a_r6_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wday && !take) |=> (snap_o[WDAY_LSB +: 3] == 3'd1));
endmodule

// File: tb/test_bcd_timekeeper.sv
`timescale 1ns/1ps
module test_bcd_timekeeper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        load_valid_i = 1'b0;
  logic        load_ready_o;
  logic [63:0] load_data_i = '0;
  logic [63:0] snap_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bcd_timekeeper i_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_valid_i(load_valid_i),
    .load_ready_o(load_ready_o), .load_data_i(load_data_i), .snap_o(snap_o));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic logic [7:0] hb12(input int h24);
    int h12;
    h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
    return 8'h80 | ((h24 >= 12) ? 8'h20 : 8'h00) | bcd(h12);
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] word(input int cs, input int s, input int mi,
      input logic [7:0] hb, input int dow, input logic stop, input logic rse,
      input int d, input int mo, input int y);
    return {bcd(y), bcd(mo), bcd(d), {2'b00, stop, rse, 1'b0, 3'(dow)}, hb,
            bcd(mi), bcd(s), bcd(cs)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] w, input logic with_tick);
    @(negedge clk);
    load_valid_i = 1'b1;
    load_data_i  = w;
    tick_i       = with_tick;
    @(negedge clk);
    load_valid_i = 1'b0;
    tick_i       = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    check("R1 reset word", snap_o, 64'h0001_0131_0000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", snap_o, 64'h0001_0131_0000_0000);
    check("R10 ready high", {63'd0, load_ready_o}, 64'd1);

    // R9: stopped from reset
    for (int i = 0; i < 5; i++) tick_once();
    check("R9 stopped after reset", snap_o, 64'h0001_0131_0000_0000);

    // R11: all-ones load, stop bit set so nothing counts
    do_load({64{1'b1}}, 1'b0);
    check("R11 gap bits zero", snap_o, 64'hFF1F_3F37_BF7F_7FFF);
    tick_once();
    check("R9 stopped after all-ones", snap_o, 64'hFF1F_3F37_BF7F_7FFF);

    // R2 / R10: byte placement and load with a simultaneous tick
    w = word(12, 34, 56, bcd(7), 5, 1'b0, 1'b1, 28, 9, 45);
    do_load(w, 1'b1);
    check("R10 load drops tick", snap_o, w);
    check("R2 minutes byte", {56'd0, snap_o[23:16]}, 64'h56);

    // R3: long run across a minute and an hour boundary
    begin
      int t;
      t = 58 * 6000 + 59 * 100;
      do_load(word(0, 59, 58, bcd(0), 2, 1'b0, 1'b1, 15, 7, 30), 1'b0);
      for (int i = 1; i <= 6200; i++) begin
        int u;
        tick_once();
        u = t + i;
        check("R3 running count", snap_o,
              word(u % 100, (u / 100) % 60, (u / 6000) % 60, bcd((u / 360000) % 24),
                   2, 1'b0, 1'b1, 15, 7, 30));
      end
    end

    // R4: every hour in 24-hour mode
    for (int h = 0; h < 24; h++) begin
      do_load(word(99, 59, 59, bcd(h), 3, 1'b0, 1'b1, 10, 5, 21), 1'b0);
      tick_once();
      check("R4 24h step", snap_o,
            word(0, 0, 0, bcd((h + 1) % 24), (h == 23) ? 4 : 3, 1'b0, 1'b1,
                 (h == 23) ? 11 : 10, 5, 21));
    end

    // R5: every hour in 12-hour mode
    for (int h = 0; h < 24; h++) begin
      do_load(word(99, 59, 59, hb12(h), 3, 1'b0, 1'b1, 10, 5, 21), 1'b0);
      tick_once();
      check("R5 12h step", snap_o,
            word(0, 0, 0, hb12((h + 1) % 24), (h == 23) ? 4 : 3, 1'b0, 1'b1,
                 (h == 23) ? 11 : 10, 5, 21));
    end

    // R6 / R7 / R8 / R12: month ends across leap and plain years
    foreach (w[i]) begin end
    for (int yi = 0; yi < 7; yi++) begin
      int y;
      y = (yi == 5) ? 96 : (yi == 6) ? 99 : yi;
      for (int m = 1; m <= 12; m++) begin
        int dow, ndow;
        logic rse;
        dow  = (m % 7) + 1;
        ndow = (dow == 7) ? 1 : dow + 1;
        rse  = m[0];
        do_load(word(99, 59, 59, bcd(23), dow, 1'b0, rse, dim(m, y) - 1, m, y), 1'b0);
        tick_once();
        check("R7 day before last", snap_o,
              word(0, 0, 0, bcd(0), ndow, 1'b0, rse, dim(m, y), m, y));
        do_load(word(99, 59, 59, bcd(23), dow, 1'b0, rse, dim(m, y), m, y), 1'b0);
        tick_once();
        check("R7 R8 R6 R12 month end", snap_o,
              word(0, 0, 0, bcd(0), ndow, 1'b0, rse, 1,
                   (m == 12) ? 1 : m + 1, (m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R12: reset-enable cleared, counting unaffected
    do_load(word(5, 0, 0, bcd(1), 1, 1'b0, 1'b0, 2, 3, 4), 1'b0);
    tick_once();
    check("R12 rsten zero kept", snap_o, word(6, 0, 0, bcd(1), 1, 1'b0, 1'b0, 2, 3, 4));

    // R9: stop bit set after running
    w = word(50, 10, 20, bcd(8), 6, 1'b1, 1'b0, 3, 3, 3);
    do_load(w, 1'b0);
    for (int i = 0; i < 10; i++) tick_once();
    check("R9 stop bit freezes", snap_o, w);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule